// File: doc/BRIEF.md
# Addressable Scan Register Bank

This block is a bank of state flip-flops for a sequential design under test. Each flip-flop can be reached on its own through a binary scan address, instead of through a shift chain. In functional mode every flip-flop loads its bit of the next-state vector from the surrounding combinational logic on each clock edge.

In test mode the bank freezes. A select strobe, together with an address, writes a single scan data bit into exactly one flip-flop. Every other flip-flop keeps its value. A single scan-out line always shows the flip-flop that the current address points to, without waiting for a clock. This lets a tester set up any state and observe any state bit with one access each, rather than shifting the whole bank.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the flip-flops start loading on the third rising clock edge after the reset input goes high.

Top module: `rascan_bank`

## Requirements
- R1: While reset is active, and until the second rising edge after its release, every bit of `state_q` is 0. The first functional load takes place on the third rising edge after `rst_n` goes high.
- R2: With `test_mode` = 0, every rising edge loads `state_q` with the value `next_state` had before that edge.
- R3: With `test_mode` = 1, `scan_sel` = 1 and `scan_addr` = i with i < N, the next edge writes `scan_din` into `state_q[i]`. The address is an unsigned binary index, and index i names bit i of `state_q`.
- R4: During an addressed write in test mode, every bit other than the addressed one keeps its value, whatever `next_state` holds.
- R5: With `test_mode` = 1 and `scan_sel` = 0, no bit of `state_q` changes on the edge.
- R6: When `scan_addr` = i < N, `scan_out` equals `state_q[i]` in the same cycle, in either mode, with no clock edge between the address and the read.
- R7: A `scan_addr` of N or more selects nothing. A test-mode write to it changes no bit, and `scan_out` reads 0 while it is applied.
- R8: `scan_sel` has no effect while `test_mode` = 0. The bank still loads `next_state` in full, whatever the address and scan data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| next_state | input | N | Next-state vector from the functional logic |
| test_mode | input | 1 | 0 selects functional loading, 1 selects addressed test access |
| scan_addr | input | AW | Binary index of the flip-flop to access |
| scan_din | input | 1 | Value written into the addressed flip-flop |
| scan_sel | input | 1 | Strobe that qualifies a test-mode write |
| state_q | output | N | Current contents of the bank |
| scan_out | output | 1 | Combinational readback of the addressed flip-flop |

## Verification
The assertions check several behaviours on every clock:
- Each flip-flop loads its next-state bit in functional mode, takes the scan bit when written, and holds otherwise.
- The write decode is never more than one-hot.
- Out-of-range addresses produce no write and read 0.
- Readback matches the addressed bit.

Some behaviours only the bench scenarios can show. These are the exact release cycle after reset, and that a value written through the address port later reads back unchanged across a sweep of all addresses. They also include that strobes in functional mode leave the loaded vector untouched, and that non-addressed bits survive long runs of writes while `next_state` toggles.

// File: rtl/rascan_pkg.sv
package rascan_pkg;

  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_TEST = 1'b1
  } mode_e;

endpackage

// File: rtl/rascan_rst_sync.sv
module rascan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rascan_cell.sv
module rascan_cell
  import rascan_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  func_d,
  input  logic  wr_en,
  input  logic  scan_d,
  output logic  q
);

  logic q_next;

  always_comb begin
    q_next = q;
    if (mode == MODE_FUNC) begin
      q_next = func_d;
    end else if (wr_en) begin
      q_next = scan_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end

  // R2: functional load
  p_func_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FUNC) |=> (q == $past(func_d)));

  // R3: addressed write
  p_scan_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TEST && wr_en) |=> (q == $past(scan_d)));

  // R4/R5: hold when not written in test mode
  p_test_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TEST && !wr_en) |=> $stable(q));

endmodule

// File: rtl/rascan_addr_dec.sv
module rascan_addr_dec
  import rascan_pkg::*;
#(
  parameter int N  = 12,
  parameter int AW = 4
) (
  input  mode_e           mode,
  input  logic            strobe,
  input  logic [AW-1:0]   addr,
  output logic [N-1:0]    wr_vec
);

  logic access_ok;

  always_comb begin
    access_ok = (mode == MODE_TEST) && strobe;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_line
    always_comb begin
      wr_vec[gi] = access_ok && (int'(addr) == gi);
    end
  end

endmodule

// File: rtl/rascan_read_mux.sv
module rascan_read_mux #(
  parameter int N  = 12,
  parameter int AW = 4
) (
  input  logic [N-1:0]  bits_i,
  input  logic [AW-1:0] addr,
  output logic          bit_o
);

  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (int'(addr) == k) bit_o = bits_i[k];
    end
  end

endmodule

// File: rtl/rascan_bank.sv
module rascan_bank
  import rascan_pkg::*;
#(
  parameter int N  = 12,
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  next_state,
  input  logic          test_mode,
  input  logic [AW-1:0] scan_addr,
  input  logic          scan_din,
  input  logic          scan_sel,
  output logic [N-1:0]  state_q,
  output logic          scan_out
);

  logic         rst_sync_n;
  mode_e        mode;
  logic [N-1:0] wr_vec;

  always_comb begin
    mode = test_mode ? MODE_TEST : MODE_FUNC;
  end

  rascan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rascan_addr_dec #(.N(N), .AW(AW)) u_dec (
    .mode   (mode),
    .strobe (scan_sel),
    .addr   (scan_addr),
    .wr_vec (wr_vec)
  );

  for (genvar gb = 0; gb < N; gb++) begin : g_bit
    rascan_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .mode   (mode),
      .func_d (next_state[gb]),
      .wr_en  (wr_vec[gb]),
      .scan_d (scan_din),
      .q      (state_q[gb])
    );
  end

  rascan_read_mux #(.N(N), .AW(AW)) u_rd (
    .bits_i (state_q),
    .addr   (scan_addr),
    .bit_o  (scan_out)
  );

  // R3: at most one flip-flop written per edge
  p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wr_vec));

  // R7: out-of-range address writes nothing
  p_oob_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(scan_addr) >= N) |-> (wr_vec == '0));

  // R7: out-of-range address reads 0
  p_oob_read_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(scan_addr) >= N) |-> (scan_out == 1'b0));

  // R6: readback matches addressed bit
  p_readback_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(scan_addr) < N) |-> (scan_out == state_q[scan_addr]));

  // R8: strobe in functional mode leaves full load intact
  p_sel_ignored_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!test_mode && scan_sel) |=> (state_q == $past(next_state)));

endmodule

// File: tb/test_rascan_bank.sv
module test_rascan_bank;

  localparam int N  = 12;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  next_state;
  logic          test_mode;
  logic [AW-1:0] scan_addr;
  logic          scan_din;
  logic          scan_sel;
  logic [N-1:0]  state_q;
  logic          scan_out;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 0;

  logic [N-1:0] model;
  int rel_cnt;

  always #2 clk = ~clk;

  rascan_bank #(.N(N), .AW(AW)) i_rascan_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_state (next_state),
    .test_mode  (test_mode),
    .scan_addr  (scan_addr),
    .scan_din   (scan_din),
    .scan_sel   (scan_sel),
    .state_q    (state_q),
    .scan_out   (scan_out)
  );

  // Behavioural reference: one bit per index, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model = '0;
      rel_cnt = 0;
    end else begin
      if (rel_cnt >= 2) begin
        if (!test_mode) model = next_state;
        else if (scan_sel && int'(scan_addr) < N) model[scan_addr] = scan_din;
      end
      rel_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string tag);
    logic exp_so;
    string so_tag;
    exp_so = (int'(scan_addr) < N) ? model[scan_addr] : 1'b0;
    so_tag = (int'(scan_addr) < N) ? "R6" : "R7";
    vectors++;
    if (state_q !== model) begin
      miscompares++;
      $display("FAIL %s state_q: actual=%h expected=%h", tag, state_q, model);
    end
    vectors++;
    if (scan_out !== exp_so) begin
      miscompares++;
      $display("FAIL %s scan_out: actual=%b expected=%b", so_tag, scan_out, exp_so);
    end
  endtask

  task automatic cyc(input logic [N-1:0] ns, input logic tm, input int ad,
                     input logic din, input logic sel, input string tag);
    next_state = ns;
    test_mode  = tm;
    scan_addr  = AW'(ad);
    scan_din   = din;
    scan_sel   = sel;
    #0;
    check(tag);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    next_state = '1; test_mode = 1'b0; scan_addr = '0; scan_din = 1'b1; scan_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // R1: two edges still held at zero, then first load
    cyc('1, 1'b0, 0, 1'b0, 1'b0, "R1");
    cyc('1, 1'b0, 0, 1'b0, 1'b0, "R1");
    cyc(N'(12'hA5C), 1'b0, 3, 1'b0, 1'b0, "R2");
    // R2: functional loading
    for (int i = 0; i < 20; i++) cyc(N'($urandom), 1'b0, i % 16, 1'b0, 1'b0, "R2");
    // R8: strobe ignored in functional mode
    for (int i = 0; i < 16; i++) cyc(N'($urandom), 1'b0, i, i[0], 1'b1, "R8");
    cyc('0, 1'b0, 0, 1'b0, 1'b0, "R2");
    // R3/R4: addressed writes, next_state toggling is ignored
    for (int i = 0; i < N; i++) cyc(N'($urandom), 1'b1, i, (i % 3) != 0, 1'b1, "R3");
    for (int i = 0; i < N; i++) cyc(N'($urandom), 1'b1, (i * 5) % N, 1'b0, 1'b1, "R4");
    // R7: out-of-range writes
    for (int i = N; i < (1 << AW); i++) cyc('1, 1'b1, i, 1'b1, 1'b1, "R7");
    // R5: strobe low holds everything
    for (int i = 0; i < 16; i++) cyc(N'($urandom), 1'b1, i, 1'b1, 1'b0, "R5");
    // R6: readback sweep in test mode and functional mode
    for (int i = 0; i < N; i++) cyc(N'($urandom), 1'b1, i, 1'b1, 1'b1, "R3");
    for (int i = 0; i < (1 << AW); i++) cyc('0, 1'b1, i, 1'b0, 1'b0, "R6");
    for (int i = 0; i < (1 << AW); i++) cyc(N'($urandom), 1'b0, i, 1'b0, 1'b0, "R6");
    // Mixed random traffic
    for (int i = 0; i < 200; i++)
      cyc(N'($urandom), 1'($urandom), int'($urandom % 16), 1'($urandom), 1'($urandom), "R3");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule